// File: doc/BRIEF.md
# Four-Channel Successive-Approximation Sequencer with Serial Result Port

This block is the digital core of a 12-bit successive-approximation converter. The analog parts (trial DAC, comparator, sample-and-hold) sit outside it. Each conversion frame starts with a one-clock sampling strobe and captures the requested input channel. The block then runs twelve bit trials, most significant bit first. On each trial it drives a code to the external DAC and reads back a one-bit comparator decision.

The result leaves on a single serial line, one bit per clock. A two-bit mode code picks one of three behaviours: a single conversion sent MSB first, continuous conversion sent LSB first, or continuous conversion sent MSB first. The fourth code disables the block. An active-low chip select starts the sequence, and deasserting it aborts the sequence. The line drivers are modelled by separate enable outputs that the pad ring uses to float the data and strobe pins.

Cycle numbering used below: cycle 0 is the clock period after the first rising edge at which `cs_ni` is seen low while idle with a valid mode. Frame k covers cycles 16k to 16k+15.

Top module: `sar_seq_top`

## Requirements
- R1: `ch_sel_o` carries the channel code as captured. Code n (0..3) selects analog input n, and the comparator must report on that input.
- R2: `mode_i` encodings are: 2'b00 single MSB-first, 2'b01 continuous LSB-first, 2'b11 continuous MSB-first, 2'b10 disabled. With 2'b10 the block stays idle. Both enables stay low, and `samp_o` and `dout_o` stay low.
- R3: After reset both enables are low. The rising edge that sees `cs_ni` high aborts any conversion, so both enables and `dout_o` are low in the following cycle. While active, both enables are high.
- R4: `samp_o` is high for exactly one cycle, cycle 16k of each frame, and low otherwise.
- R5: The trials run in frame cycles 4..15. Frame cycle 4+t tries bit 11-t. `dac_code_o` is the bits already kept, plus the trial bit. A comparator 1 keeps the bit. Outside trials `dac_code_o` is 0.
- R6: In the MSB-first modes, bit 11-j of frame k's result is on `dout_o` in cycle 16k+6+j, for j = 0..11. The first bit therefore comes five clocks after the strobe falls.
- R7: In mode 2'b00 only frame 0 is converted. Bit 0 appears in cycle 17. After that `dout_o` stays low, no further strobe is issued, and both enables stay high until `cs_ni` is raised. A later fall of `cs_ni` starts afresh.
- R8: In mode 2'b01, frame k's result is held and sent in frame k+1, LSB first. Bit j is on `dout_o` in cycle 16(k+1)+4+j, so the first bit appears in cycle 20.
- R9: In the continuous modes, frames repeat back to back every 16 cycles while `cs_ni` stays low.
- R10: `chan_i` is captured at the rising edge that ends each strobe cycle. `ch_sel_o` changes at no other time, so a code set before that edge applies to that frame.
- R11: `dout_o` is low in every cycle in which no result bit is scheduled by R6, R7 or R8.
- R12: The mode is captured when a conversion sequence starts. Changes on `mode_i` during the sequence have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; high aborts and disables |
| chan_i | input | 2 | Requested analog channel code |
| mode_i | input | 2 | Conversion mode code |
| cmp_i | input | 1 | Comparator decision: 1 when input is at or above the trial code |
| dac_code_o | output | 12 | Trial code for the external DAC |
| ch_sel_o | output | 2 | Captured channel code for the input multiplexer |
| samp_o | output | 1 | Sampling strobe |
| samp_oe_o | output | 1 | Output enable for the strobe pin |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for the data pin |

## Verification
The bench models the comparator as a compare between a per-channel 12-bit input value and the trial code, so every serial bit checks the whole trial search against a known answer. Input values of all zeros and all ones catch stuck or inverted trial bits, and random values catch misordered bits. Each mode runs over several frames with the channel changed between strobes, which separates MSB-first streaming from the LSB-first delayed latch and shows whether a channel lands in the right frame. Mid-frame aborts, the disabled code, and a mode change during a sequence check that the sequence stops or carries on as required.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_CONT_LSB = 2'b01,
    MODE_OFF      = 2'b10,
    MODE_CONT_MSB = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } state_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int FRAME  = 16,
  parameter int SETTLE = 4,
  parameter int CW     = 2,
  localparam int CYW   = $clog2(FRAME)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic [CW-1:0]  chan_i,
  input  logic [1:0]     mode_i,
  output logic           active_o,
  output logic           running_o,
  output logic           samp_o,
  output logic           trial_o,
  output logic           frame_end_o,
  output logic           lsb_o,
  output logic [CYW-1:0] cyc_o,
  output logic [CW-1:0]  chan_o
);
  state_e         state_q;
  mode_e          mode_q;
  logic [CYW-1:0] cyc_q;
  logic [CW-1:0]  chan_q;

  localparam logic [CYW-1:0] LAST  = CYW'(FRAME - 1);
  localparam logic [CYW-1:0] TRIAL = CYW'(SETTLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_SINGLE;
      cyc_q   <= '0;
      chan_q  <= '0;
    end else if (cs_ni) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (mode_e'(mode_i) != MODE_OFF) begin
            state_q <= ST_RUN;
            mode_q  <= mode_e'(mode_i);
            cyc_q   <= '0;
          end
        end
        ST_RUN: begin
          cyc_q <= (cyc_q == LAST) ? '0 : cyc_q + 1'b1;
          // channel captured at the edge closing the strobe cycle
          if (cyc_q == '0) chan_q <= chan_i;
          if (cyc_q == LAST && mode_q == MODE_SINGLE) state_q <= ST_DONE;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign active_o    = (state_q != ST_IDLE);
  assign running_o   = (state_q == ST_RUN);
  assign samp_o      = running_o && (cyc_q == '0);
  assign trial_o     = running_o && (cyc_q >= TRIAL);
  assign frame_end_o = running_o && (cyc_q == LAST);
  assign lsb_o       = (mode_q == MODE_CONT_LSB);
  assign cyc_o       = cyc_q;
  assign chan_o      = chan_q;

  // R4
  samp_one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o |=> !samp_o);

  // R10
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_q != $past(chan_q)) |-> $past(samp_o));

  // R7
  single_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_o && mode_q == MODE_SINGLE && !cs_ni) |=> !running_o && active_o);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int NBITS = 12,
  parameter int FRAME = 16,
  localparam int CYW  = $clog2(FRAME),
  localparam int IW   = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             trial_i,
  input  logic             frame_end_i,
  input  logic [CYW-1:0]   cyc_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] dac_code_o,
  output logic [NBITS-1:0] result_o
);
  logic [NBITS-1:0] sar_q;
  logic [CYW-1:0]   rem;
  logic [IW-1:0]    idx;
  logic [NBITS-1:0] onehot;

  assign rem    = CYW'(FRAME - 1) - cyc_i;
  assign idx    = rem[IW-1:0];
  assign onehot = NBITS'(1) << idx;

  assign dac_code_o = trial_i ? (sar_q | onehot) : '0;
  assign result_o   = sar_q | ((trial_i && cmp_i) ? onehot : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       sar_q <= '0;
    else if (!active_i || frame_end_i) sar_q <= '0;
    else if (trial_i && cmp_i)         sar_q <= sar_q | onehot;
  end

  // R5
  trial_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trial_i && !frame_end_i && active_i) |=> ((sar_q & $past(sar_q)) == $past(sar_q)));
endmodule

// File: rtl/sar_ser_out.sv
module sar_ser_out #(
  parameter int NBITS  = 12,
  parameter int SETTLE = 4,
  parameter int FRAME  = 16,
  localparam int CYW   = $clog2(FRAME)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             cs_ni,
  input  logic             running_i,
  input  logic             lsb_i,
  input  logic             trial_i,
  input  logic             cmp_i,
  input  logic             frame_end_i,
  input  logic [NBITS-1:0] result_i,
  input  logic [CYW-1:0]   cyc_i,
  output logic             dout_o
);
  localparam logic [CYW-1:0] SH_LO = CYW'(SETTLE - 1);
  localparam logic [CYW-1:0] SH_HI = CYW'(SETTLE + NBITS - 2);

  logic             bit_q, bit_vld_q, have_q, dout_q;
  logic [NBITS-1:0] hold_q;
  logic             shift_win;

  assign shift_win = running_i && have_q && (cyc_i >= SH_LO) && (cyc_i <= SH_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q     <= 1'b0;
      bit_vld_q <= 1'b0;
      have_q    <= 1'b0;
      hold_q    <= '0;
      dout_q    <= 1'b0;
    end else if (!active_i || cs_ni) begin
      bit_q     <= 1'b0;
      bit_vld_q <= 1'b0;
      have_q    <= 1'b0;
      hold_q    <= '0;
      dout_q    <= 1'b0;
    end else if (lsb_i) begin
      // previous result leaves LSB first while the next one is being built
      bit_vld_q <= 1'b0;
      if (frame_end_i) begin
        hold_q <= result_i;
        have_q <= 1'b1;
      end else if (shift_win) begin
        hold_q <= hold_q >> 1;
      end
      dout_q <= shift_win & hold_q[0];
    end else begin
      // MSB first: each decision streams out two edges after its trial
      bit_q     <= cmp_i;
      bit_vld_q <= trial_i;
      dout_q    <= bit_vld_q & bit_q;
    end
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int NBITS  = 12,
  parameter int SETTLE = 4,
  parameter int NCH    = 4,
  localparam int FRAME = SETTLE + NBITS,
  localparam int CYW   = $clog2(FRAME),
  localparam int CW    = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic [CW-1:0]    chan_i,
  input  logic [1:0]       mode_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] dac_code_o,
  output logic [CW-1:0]    ch_sel_o,
  output logic             samp_o,
  output logic             samp_oe_o,
  output logic             dout_o,
  output logic             dout_oe_o
);
  logic           active, running, trial, frame_end, lsb;
  logic [CYW-1:0] cyc;
  logic [NBITS-1:0] result;

  sar_seq_ctrl #(.FRAME(FRAME), .SETTLE(SETTLE), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .chan_i, .mode_i,
    .active_o(active), .running_o(running), .samp_o(samp_o), .trial_o(trial),
    .frame_end_o(frame_end), .lsb_o(lsb), .cyc_o(cyc), .chan_o(ch_sel_o)
  );

  sar_trial_reg #(.NBITS(NBITS), .FRAME(FRAME)) u_trial (
    .clk_i, .rst_ni, .active_i(active), .trial_i(trial), .frame_end_i(frame_end),
    .cyc_i(cyc), .cmp_i, .dac_code_o(dac_code_o), .result_o(result)
  );

  sar_ser_out #(.NBITS(NBITS), .SETTLE(SETTLE), .FRAME(FRAME)) u_ser (
    .clk_i, .rst_ni, .active_i(active), .cs_ni, .running_i(running), .lsb_i(lsb),
    .trial_i(trial), .cmp_i, .frame_end_i(frame_end), .result_i(result),
    .cyc_i(cyc), .dout_o(dout_o)
  );

  assign samp_oe_o = active;
  assign dout_oe_o = active;

  // R3
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!dout_oe_o && !samp_oe_o && !dout_o));

  // R11
  dout_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_oe_o |-> !dout_o);
endmodule

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic [1:0]  chan_i = '0;
  logic [1:0]  mode_i = '0;
  logic        cmp_i;
  logic [11:0] dac_code_o;
  logic [1:0]  ch_sel_o;
  logic        samp_o, samp_oe_o, dout_o, dout_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [11:0] vin [4];
  logic [1:0]  chans [8];

  always #5 clk = ~clk;

  // comparator model (R1: ch_sel_o picks the input)
  assign cmp_i = (vin[ch_sel_o] >= dac_code_o);

  sar_seq_top dut_i (
    .clk_i(clk), .rst_ni, .cs_ni, .chan_i, .mode_i, .cmp_i,
    .dac_code_o, .ch_sel_o, .samp_o, .samp_oe_o, .dout_o, .dout_oe_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic exp_dout(input logic [1:0] md, input int n);
    int k, off;
    if (md == 2'b01) begin
      if (n < 20) return 1'b0;
      k = (n - 4) / 16;
      off = n - 16 * k;
      if (off > 15) return 1'b0;
      return vin[chans[k-1]][off-4];
    end
    if (n < 6) return 1'b0;
    k = (n - 6) / 16;
    off = n - 16 * k;
    if (off > 17) return 1'b0;
    if (md == 2'b00 && k > 0) return 1'b0;
    return vin[chans[k]][11-(off-6)];
  endfunction

  function automatic logic exp_samp(input logic [1:0] md, input int n);
    if (md == 2'b00) return (n == 0);
    return (n % 16 == 0);
  endfunction

  task automatic run(input logic [1:0] md, input int ncyc, input bit sw);
    logic e;
    mode_i = md;
    chan_i = chans[0];
    cs_ni  = 1'b0;
    for (int n = 0; n < ncyc; n++) begin
      @(negedge clk);
      e = exp_dout(md, n);
      // R5 R6 R8 bit values; R11 quiet cycles
      chk(dout_o == e, e ? (md == 2'b01 ? "R5 R8" : "R5 R6") : "R11", dout_o, e);
      chk(samp_o == exp_samp(md, n), (md == 2'b00 && n >= 16) ? "R7" : (n >= 16 ? "R9" : "R4"),
          samp_o, exp_samp(md, n));
      chk(dout_oe_o && samp_oe_o, "R3", {dout_oe_o, samp_oe_o}, 3);
      if (n % 16 != 0 && (md != 2'b00 || n < 16))
        chk(ch_sel_o == chans[n/16], "R1 R10", ch_sel_o, chans[n/16]);
      if (n % 16 == 2 && n / 16 + 1 < 8) chan_i = chans[n/16+1];
      if (n % 16 == 9) chan_i = ~chans[n/16+1]; // R10: not captured mid-frame
      if (n % 16 == 12 && n / 16 + 1 < 8) chan_i = chans[n/16+1];
      if (sw && n == 5) mode_i = 2'b00; // R12
    end
    cs_ni = 1'b1;
    @(negedge clk);
    chk(!dout_oe_o && !samp_oe_o && !dout_o, "R3", {dout_oe_o, samp_oe_o, dout_o}, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_rand();
    for (int i = 0; i < 4; i++) vin[i] = 12'($urandom);
    for (int i = 0; i < 8; i++) chans[i] = 2'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) vin[i] = '0;
    for (int i = 0; i < 8; i++) chans[i] = 2'(i);
    repeat (3) @(negedge clk);
    // R3 reset state
    chk(!dout_oe_o && !samp_oe_o && !dout_o && !samp_o, "R3",
        {dout_oe_o, samp_oe_o, dout_o, samp_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2 disabled code
    mode_i = 2'b10;
    cs_ni = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      chk(!dout_oe_o && !samp_oe_o && !samp_o && !dout_o, "R2",
          {dout_oe_o, samp_oe_o, samp_o, dout_o}, 0);
    end
    cs_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R5 extreme codes, all modes
    for (int i = 0; i < 4; i++) vin[i] = 12'hFFF;
    run(2'b11, 84, 0);
    vin[0] = 12'h000; vin[1] = 12'hFFF; vin[2] = 12'h800; vin[3] = 12'h7FF;
    run(2'b01, 84, 0);
    run(2'b00, 45, 0);  // R7 stop, then restart below
    run(2'b00, 45, 0);

    // R3 mid-frame abort then clean restart
    set_rand();
    run(2'b11, 10, 0);
    run(2'b11, 50, 0);
    run(2'b01, 9, 0);
    run(2'b01, 52, 0);

    // R12 mode change while running is ignored
    set_rand();
    run(2'b11, 84, 1);
    set_rand();
    run(2'b01, 84, 1);

    // random mixes
    for (int it = 0; it < 10; it++) begin
      logic [1:0] md;
      set_rand();
      case (it % 3)
        0: md = 2'b00;
        1: md = 2'b01;
        default: md = 2'b11;
      endcase
      run(md, md == 2'b00 ? 40 : 100, 0);
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule